// File: doc/BRIEF.md
# Programmable Wait-State Acknowledge Generator

This block produces the processor handshake for one memory access. A single active-low pin, `hs_n`, has two personalities chosen by a static configuration bit. In stall mode it is pulled low while the access is still in progress and released when the processor may go on. In acknowledge mode it stays high while the access is in progress and is pulled low once the access has been carried out.

An access begins when the arbiter pulses `acc_start` while `acc_req` is high. The block then waits a programmed number of clock events before it ends the wait condition. It can count those events in one of two ways: as rising clock edges, or as low clock phases. The low-phase form finishes half a clock earlier, through a falling-edge stage.

While the count is running, the `wait_inc` input can stretch it at run time. Each rising edge that samples it high adds one more rising edge, up to a per-access limit. The configuration inputs are expected to stay static while an access is active.

Top module: `ack_delay_gen`

## Requirements
- R1: While reset is held and right after it, `hs_n` is high in both modes.
- R2: With `cfg_ack_mode`=0 (stall mode), `hs_n` goes low just after the rising edge that accepts a start. It stays low until the wait ends, and it is high at every other time.
- R3: With `cfg_ack_mode`=1 (acknowledge mode), `hs_n` is high while waiting. It goes low when the wait ends and stays low while `acc_req` stays high. It returns high after the first rising edge that samples `acc_req` low.
- R4: With `cfg_low_phase`=0, a delay D with no stretching ends the wait right after rising edge number D+1 following the start edge. D=0 ends it on the very next rising edge.
- R5: With `cfg_low_phase`=1, the wait ends at the falling edge that follows rising edge number D after the start edge. D=0 ends it in the low phase right after the start edge.
- R6: A rising edge that samples `wait_inc` high adds one rising edge to the count. This applies to the start edge too, and to any later edge while the remaining count is above zero. At most EXT_MAX (default 3) edges are added per access.
- R7: If `acc_req` is sampled low during the wait, the access is dropped. `hs_n` is high after that edge, and no acknowledge follows.
- R8: A start is taken only when the block is idle and `acc_req` is high. A start with `acc_req` low, or during an access, has no effect on `hs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edges are counted, and falling edges are used in low-phase mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ack_mode | input | 1 | 0 = stall pin, 1 = acknowledge pin |
| cfg_low_phase | input | 1 | 0 = count rising edges, 1 = end on a low clock phase |
| cfg_delay | input | DLY_W | Programmed number of wait events |
| acc_start | input | 1 | Access start pulse from the arbiter |
| acc_req | input | 1 | Access request, held for the whole access |
| wait_inc | input | 1 | Run-time stretch of the count |
| hs_n | output | 1 | Handshake pin, active low |

## Verification
A vector table covers every pairing of pin personality and counting form. Delays run from zero to the largest code, and stretch pulses run from none to past the limit. The bench measures, in half clocks, the point where the pin first shows termination. This separates the rising-edge form from the low-phase form by exactly one half clock, and it exposes any off-by-one in the count. Long stretch bursts show whether the limit saturates or wraps. Directed sequences then try aborts in both modes, starts with no request, and a second start pulse while an acknowledge is held. Each of these would visibly pull or release the pin if it were wrongly accepted.

// File: rtl/ackgen_pkg.sv
package ackgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/ackgen_counter.sv
module ackgen_counter
  import ackgen_pkg::*;
#(
  parameter int DLY_W   = 4,
  parameter int EXT_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req,
  input  logic             inc,
  input  logic [DLY_W-1:0] delay,
  output ack_state_e       state,
  output logic             rem_zero
);
  localparam int EXT_W = $clog2(EXT_MAX + 2);
  localparam int CNT_W = DLY_W + EXT_W;

  logic [CNT_W-1:0] rem_q;
  logic [EXT_W-1:0] ext_q;
  logic             room;
  logic             take;

  assign room     = (ext_q < EXT_W'(EXT_MAX));
  assign take     = inc && room;
  assign rem_zero = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rem_q <= '0;
      ext_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          ext_q <= '0;
          if (start && req) begin
            state <= ST_COUNT;
            rem_q <= CNT_W'(delay) + CNT_W'(take);
            ext_q <= EXT_W'(take);
          end
        end
        ST_COUNT: begin
          if (!req) begin
            state <= ST_IDLE;
          end else if (rem_zero) begin
            state <= ST_DONE;
          end else begin
            if (!take) rem_q <= rem_q - 1'b1;
            ext_q <= ext_q + EXT_W'(take);
          end
        end
        ST_DONE: begin
          ext_q <= '0;
          if (!req) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ackgen_phase.sv
module ackgen_phase
  import ackgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ack_state_e state,
  input  logic       rem_zero,
  output logic       low_done
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) low_done <= 1'b0;
    else        low_done <= (state == ST_COUNT) && rem_zero;
  end
endmodule

// File: rtl/ackgen_pin.sv
module ackgen_pin
  import ackgen_pkg::*;
(
  input  ack_state_e state,
  input  logic       low_done,
  input  logic       ack_mode,
  input  logic       low_mode,
  output logic       hs_n
);
  logic early;
  logic waiting;
  logic finished;

  always_comb begin
    early    = (state == ST_COUNT) && low_mode && low_done;
    waiting  = (state == ST_COUNT) && !early;
    finished = (state == ST_DONE) || early;
    hs_n     = ack_mode ? !finished : !waiting;
  end
endmodule

// File: rtl/ack_delay_gen.sv
module ack_delay_gen
  import ackgen_pkg::*;
#(
  parameter int DLY_W   = 4,
  parameter int EXT_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ack_mode,
  input  logic             cfg_low_phase,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             acc_start,
  input  logic             acc_req,
  input  logic             wait_inc,
  output logic             hs_n
);
  ack_state_e state;
  logic       rem_zero;
  logic       low_done;

  ackgen_counter #(.DLY_W(DLY_W), .EXT_MAX(EXT_MAX)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc_start),
    .req      (acc_req),
    .inc      (wait_inc),
    .delay    (cfg_delay),
    .state    (state),
    .rem_zero (rem_zero)
  );

  ackgen_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .rem_zero (rem_zero),
    .low_done (low_done)
  );

  ackgen_pin u_pin (
    .state    (state),
    .low_done (low_done),
    .ack_mode (cfg_ack_mode),
    .low_mode (cfg_low_phase),
    .hs_n     (hs_n)
  );
endmodule

// File: rtl/ackgen_checker.sv
module ackgen_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_ack_mode,
  input logic acc_start,
  input logic acc_req,
  input logic hs_n
);
  // R7 and R3: a request sampled low leaves the pin high
  assert_release_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> hs_n);

  // R3: an acknowledge is held while the request stays up
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ack_mode && !hs_n && acc_req) |=> !hs_n);

  // R8: a stall is only shown for an access that had its request
  assert_stall_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ack_mode && !hs_n) |-> $past(acc_req));

  // R2: the stall pin only falls after an accepted start
  assert_stall_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ack_mode && $fell(hs_n)) |-> ($past(acc_start) && $past(acc_req)));
endmodule

bind ack_delay_gen ackgen_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_ack_mode (cfg_ack_mode),
  .acc_start    (acc_start),
  .acc_req      (acc_req),
  .hs_n         (hs_n)
);

// File: tb/ack_delay_gen_tb_top.sv
module ack_delay_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ack_mode = 1'b0;
  logic       cfg_low_phase = 1'b0;
  logic [3:0] cfg_delay = '0;
  logic       acc_start = 1'b0;
  logic       acc_req = 1'b0;
  logic       wait_inc = 1'b0;
  logic       hs_n;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ack_delay_gen #(.DLY_W(4), .EXT_MAX(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ack_mode(cfg_ack_mode),
    .cfg_low_phase(cfg_low_phase), .cfg_delay(cfg_delay),
    .acc_start(acc_start), .acc_req(acc_req), .wait_inc(wait_inc), .hs_n(hs_n)
  );

  // fields: [16] ack mode, [15] low phase, [14:11] delay, [10:8] stretch edges, [7:0] half clocks to end
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 1'b0, 4'd0,  3'd0, 8'd2},
    {1'b1, 1'b0, 4'd3,  3'd0, 8'd8},
    {1'b0, 1'b1, 4'd0,  3'd0, 8'd1},
    {1'b1, 1'b1, 4'd5,  3'd0, 8'd11},
    {1'b0, 1'b0, 4'd2,  3'd2, 8'd10},
    {1'b1, 1'b1, 4'd1,  3'd1, 8'd5},
    {1'b1, 1'b0, 4'd0,  3'd5, 8'd8},
    {1'b0, 1'b1, 4'd15, 3'd0, 8'd31},
    {1'b1, 1'b0, 4'd15, 3'd3, 8'd38},
    {1'b0, 1'b1, 4'd2,  3'd3, 8'd11}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // start an access; returns after the start edge plus 1 ns
  task automatic begin_access(input bit am, input bit lp, input int d, input bit inc0);
    @(posedge clk); #2;
    cfg_ack_mode = am; cfg_low_phase = lp; cfg_delay = 4'(d);
    acc_start = 1'b1; acc_req = 1'b1; wait_inc = inc0;
    @(posedge clk); #1;
    acc_start = 1'b0;
  endtask

  task automatic end_access;
    @(posedge clk); #2;
    acc_req = 1'b0; wait_inc = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    // R1: reset state in both modes
    #3;
    check(hs_n == 1'b1, "R1 reset stall mode", hs_n, 1);
    cfg_ack_mode = 1'b1; #1;
    check(hs_n == 1'b1, "R1 reset ack mode", hs_n, 1);
    #10; rst_n = 1'b1;
    @(posedge clk); #1;
    check(hs_n == 1'b1, "R1 after reset", hs_n, 1);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      logic [16:0] v;
      int w;
      int exp_k;
      int got_k;
      int j;
      v = VEC[i];
      w = int'(v[10:8]);
      exp_k = int'(v[7:0]);
      got_k = 0;
      j = 0;
      begin_access(v[16], v[15], int'(v[14:11]), w > 0);
      wait_inc = (1 < w);
      for (int k = 1; k <= 80 && got_k == 0; k++) begin
        @(clk); #1;
        if (clk) begin
          j++;
          wait_inc = (j + 1 < w);
        end
        if (v[16] ? (hs_n == 1'b0) : (hs_n == 1'b1)) got_k = k;
      end
      check(got_k == exp_k, $sformatf("R4 R5 R6 vector %0d end point", i), got_k, exp_k);
      if (v[16]) begin
        @(posedge clk); #1;
        check(hs_n == 1'b0, $sformatf("R3 vector %0d hold", i), hs_n, 0);
      end else begin
        @(posedge clk); #1;
        check(hs_n == 1'b1, $sformatf("R2 vector %0d high after end", i), hs_n, 1);
      end
      end_access();
      check(hs_n == 1'b1, $sformatf("R3 vector %0d release", i), hs_n, 1);
    end

    // R8: start without request is ignored
    @(posedge clk); #2;
    cfg_ack_mode = 1'b0; cfg_low_phase = 1'b0; cfg_delay = 4'd3;
    acc_start = 1'b1; acc_req = 1'b0;
    @(posedge clk); #1; acc_start = 1'b0;
    @(posedge clk); #1;
    check(hs_n == 1'b1, "R8 start without request", hs_n, 1);

    // R7: abort in stall mode
    begin_access(1'b0, 1'b0, 10, 1'b0);
    check(hs_n == 1'b0, "R2 stall shown", hs_n, 0);
    repeat (2) @(posedge clk);
    end_access();
    check(hs_n == 1'b1, "R7 stall abort", hs_n, 1);
    begin
      int lows;
      lows = 0;
      for (int c = 0; c < 15; c++) begin
        @(posedge clk); #1;
        if (hs_n == 1'b0) lows++;
      end
      check(lows == 0, "R7 no stall after abort", lows, 0);
    end

    // R7: abort in acknowledge mode, no acknowledge follows
    begin_access(1'b1, 1'b0, 4, 1'b0);
    @(posedge clk);
    end_access();
    begin
      int lows;
      lows = 0;
      for (int c = 0; c < 10; c++) begin
        @(posedge clk); #1;
        if (hs_n == 1'b0) lows++;
      end
      check(lows == 0, "R7 no acknowledge after abort", lows, 0);
    end

    // R8: second start while acknowledge is held is ignored
    begin_access(1'b1, 1'b0, 0, 1'b0);
    @(posedge clk); #1;
    check(hs_n == 1'b0, "R4 zero delay acknowledge", hs_n, 0);
    #1; acc_start = 1'b1;
    @(posedge clk); #1; acc_start = 1'b0;
    begin
      int highs;
      highs = 0;
      for (int c = 0; c < 3; c++) begin
        @(posedge clk); #1;
        if (hs_n == 1'b1) highs++;
      end
      check(highs == 0, "R8 restart during acknowledge", highs, 0);
    end
    end_access();
    check(hs_n == 1'b1, "R3 release after restart attempt", hs_n, 1);

    finished = 1'b1;
    report();
  end
endmodule